// File: doc/BRIEF.md
# Depth-Cascade Token Controller

This controller sits next to one FIFO in a ring of identical FIFOs and decides whether the local FIFO may currently accept writes and deliver reads. With it, the ring behaves as one deeper FIFO. Two tokens travel around the ring: a write token and a read token. When the local FIFO reports that it has written its last location, the controller gives up the write token and sends a one-cycle pulse on its expansion output. When the FIFO reports that it has read its last location, the controller does the same for the read token. The next device in the ring takes these pulses on its expansion input. It decodes them by alternation: the first pulse grants write ownership and the next grants read ownership.

A strap, active low, marks the device that is loaded first. After reset that device owns both tokens. If the expansion input is held at its active level while reset is applied, the controller latches single-device mode. In that mode the device owns both tokens permanently, the ring logic is bypassed, and the expansion output carries the half-full flag instead of pulses. User write and read strobes are gated by the tokens. The parallel output enable follows the read token.

Top module: `xcas_ctrl`

## Requirements
- R1: During reset in cascade mode, `first_load_n` low gives the device both tokens (`wr_tok`=1, `rd_tok`=1), and `first_load_n` high gives it neither.
- R2: If `xin` is low (active) on the reset cycles, single-device mode is latched. Both tokens then stay 1 whatever the strap, the FIFO events or `xin` do, and `xout` equals the inverse of `half_full`.
- R3: `wr_en` is 1 only when `wr_req` is 1 and the write token is held. `rd_en` is 1 only when `rd_req` is 1 and the read token is held. `oe` is 1 exactly when the read token is held.
- R4: In cascade mode, `last_wr` while holding the write token clears `wr_tok` at that edge. `xout` is then driven low for one cycle starting at the following edge.
- R5: In cascade mode, `last_rd` while holding the read token clears `rd_tok` at that edge. A one-cycle low pulse on `xout` follows in the same way.
- R6: Every expansion pulse lasts exactly one cycle and is followed by at least `PULSE_GAP` idle-high cycles (default 1). If the write and read hand-offs are both pending, the write pulse goes out first.
- R7: In cascade mode each cycle with `xin` low counts as one received pulse, and the token is granted at that edge. Counting from reset, odd-numbered pulses grant the write token and even-numbered pulses grant the read token. With no pulse, no token is gained.
- R8: A `last_wr` or `last_rd` event at a device that lacks the matching token produces no pulse and no change to either token.
- R9: In cascade mode with no hand-off pending, `xout` idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| first_load_n | input | 1 | Strap, low marks the device loaded first |
| xin | input | 1 | Expansion input from the previous device, pulses active low |
| half_full | input | 1 | Local half-full flag, active high |
| last_wr | input | 1 | Local FIFO wrote its last location |
| last_rd | input | 1 | Local FIFO read its last location |
| wr_req | input | 1 | User write strobe |
| rd_req | input | 1 | User read strobe |
| wr_en | output | 1 | Gated write strobe to the local FIFO |
| rd_en | output | 1 | Gated read strobe to the local FIFO |
| oe | output | 1 | Parallel output drive enable |
| wr_tok | output | 1 | Write token held |
| rd_tok | output | 1 | Read token held |
| xout | output | 1 | Expansion output: pulses, or inverted half-full in single mode |

## Verification
The bench first checks that the hand-off pulse comes exactly one cycle after the token drops and lasts one cycle. A design with an extra stage would hold or delay the pulse, and the next device would see it twice or too late. It then fires both last-location events on the same edge. The check is that two separate pulses come out, write first, with an idle gap between them; a design that merges them would let the next device gain only the write token. Received pulses are applied one by one to show that write and read grants alternate. Single-device mode is set up with the strap both ways, to show that events and `xin` are ignored and that `xout` follows half-full. Stray events at a device without tokens are checked to emit nothing.

// File: rtl/xcas_pkg.sv
package xcas_pkg;
   typedef enum logic {
      EXP_WR = 1'b0,
      EXP_RD = 1'b1
   } xcas_expect_e;
endpackage

// File: rtl/xcas_token.sv
module xcas_token (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic single,
   input  logic grant,
   input  logic drop,
   output logic tok
);
   always_ff @(posedge clk) begin
      if (!rst_n)      tok <= init;
      else if (single) tok <= 1'b1;
      else if (drop)   tok <= 1'b0;
      else if (grant)  tok <= 1'b1;
   end
endmodule

// File: rtl/xcas_rx.sv
module xcas_rx
   import xcas_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic single,
   input  logic pulse_in,
   output logic grant_wr,
   output logic grant_rd
);
   xcas_expect_e exp_q;
   logic         hit;

   assign hit      = pulse_in & ~single;
   assign grant_wr = hit & (exp_q == EXP_WR);
   assign grant_rd = hit & (exp_q == EXP_RD);

   always_ff @(posedge clk) begin
      if (!rst_n)   exp_q <= EXP_WR;
      else if (hit) exp_q <= (exp_q == EXP_WR) ? EXP_RD : EXP_WR;
   end
endmodule

// File: rtl/xcas_tx.sv
module xcas_tx #(
   parameter int PULSE_GAP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic single,
   input  logic req_wr,
   input  logic req_rd,
   output logic pulse
);
   localparam int GAP_W = (PULSE_GAP < 2) ? 1 : $clog2(PULSE_GAP);

   logic             pend_wr, pend_rd, emit, sel_wr;
   logic [GAP_W-1:0] gap;

   assign emit   = ~pulse & (gap == '0) & (pend_wr | pend_rd);
   assign sel_wr = pend_wr;

   always_ff @(posedge clk) begin
      if (!rst_n || single) begin
         pend_wr <= 1'b0;
         pend_rd <= 1'b0;
         pulse   <= 1'b0;
         gap     <= '0;
      end else begin
         pend_wr <= (pend_wr & ~(emit & sel_wr)) | req_wr;
         pend_rd <= (pend_rd & ~(emit & ~sel_wr)) | req_rd;
         if (pulse) begin
            pulse <= 1'b0;
            gap   <= GAP_W'(PULSE_GAP - 1);
         end else if (gap != '0) begin
            gap <= gap - 1'b1;
         end else if (emit) begin
            pulse <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/xcas_ctrl.sv
module xcas_ctrl #(
   parameter int PULSE_GAP = 1,
   parameter bit ACT_LOW   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic first_load_n,
   input  logic xin,
   input  logic half_full,
   input  logic last_wr,
   input  logic last_rd,
   input  logic wr_req,
   input  logic rd_req,
   output logic wr_en,
   output logic rd_en,
   output logic oe,
   output logic wr_tok,
   output logic rd_tok,
   output logic xout
);
   generate
      if (PULSE_GAP < 1) begin : g_bad_gap
         $error("xcas_ctrl: PULSE_GAP must be at least 1");
      end
   endgenerate

   logic xin_act, single_q, first_q;
   logic drop_wr, drop_rd, grant_wr, grant_rd, pulse;

   generate
      if (ACT_LOW) begin : g_low
         assign xin_act = ~xin;
         assign xout    = single_q ? ~half_full : ~pulse;
      end else begin : g_high
         assign xin_act = xin;
         assign xout    = single_q ? half_full : pulse;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) single_q <= xin_act;
   end

   assign first_q = ~first_load_n;
   assign drop_wr = last_wr & wr_tok & ~single_q;
   assign drop_rd = last_rd & rd_tok & ~single_q;

   xcas_token u_wtok (
      .clk(clk), .rst_n(rst_n), .init(first_q | xin_act), .single(single_q),
      .grant(grant_wr), .drop(drop_wr), .tok(wr_tok));

   xcas_token u_rtok (
      .clk(clk), .rst_n(rst_n), .init(first_q | xin_act), .single(single_q),
      .grant(grant_rd), .drop(drop_rd), .tok(rd_tok));

   xcas_rx u_rx (
      .clk(clk), .rst_n(rst_n), .single(single_q), .pulse_in(xin_act),
      .grant_wr(grant_wr), .grant_rd(grant_rd));

   xcas_tx #(.PULSE_GAP(PULSE_GAP)) u_tx (
      .clk(clk), .rst_n(rst_n), .single(single_q),
      .req_wr(drop_wr), .req_rd(drop_rd), .pulse(pulse));

   assign wr_en = wr_req & wr_tok;
   assign rd_en = rd_req & rd_tok;
   assign oe    = rd_tok;
endmodule

// File: rtl/xcas_ctrl_chk.sv
module xcas_ctrl_chk #(
   parameter bit ACT_LOW = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic single_q,
   input logic xin_act,
   input logic xout,
   input logic last_wr,
   input logic last_rd,
   input logic wr_tok,
   input logic rd_tok
);
   logic xo_act;
   assign xo_act = ACT_LOW ? ~xout : xout;

   AST_SINGLE_TOKENS: assert property (@(posedge clk) disable iff (!rst_n)
      single_q |-> (wr_tok && rd_tok)); // R2
   AST_WR_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!single_q && wr_tok && last_wr) |=> !wr_tok); // R4
   AST_RD_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!single_q && rd_tok && last_rd) |=> !rd_tok); // R5
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (!single_q && xo_act) |=> !xo_act); // R6
   AST_NO_FREE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (!single_q && !wr_tok && !xin_act) |=> !wr_tok); // R7
endmodule

bind xcas_ctrl xcas_ctrl_chk #(.ACT_LOW(ACT_LOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .single_q(single_q), .xin_act(xin_act),
   .xout(xout), .last_wr(last_wr), .last_rd(last_rd),
   .wr_tok(wr_tok), .rd_tok(rd_tok));

// File: tb/sim_xcas_ctrl.sv
module sim_xcas_ctrl;
   logic clk = 1'b0;
   logic rst_n, first_load_n, xin, half_full, last_wr, last_rd, wr_req, rd_req;
   logic wr_en, rd_en, oe, wr_tok, rd_tok, xout;
   int   total = 0, bad = 0;
   bit   done = 0;

   always #2 clk = ~clk;

   xcas_ctrl u0 (.*);

   // {strap_n, wr_req, rd_req, exp wr_en, exp rd_en, exp oe}
   localparam logic [5:0] VEC [8] = '{
      6'b000001, 6'b010101, 6'b001011, 6'b011111,
      6'b100000, 6'b110000, 6'b101000, 6'b111000 };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string req, logic [3:0] act, logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(logic strap_n, logic xin_lvl);
      rst_n = 1'b0; first_load_n = strap_n; xin = xin_lvl;
      last_wr = 0; last_rd = 0; wr_req = 0; rd_req = 0; half_full = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      xin = 1'b1;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 / R3: table of strap and strobe patterns
      for (int i = 0; i < 8; i++) begin
         do_reset(VEC[i][5], 1'b1);
         check("R1", {2'b0, wr_tok, rd_tok}, {2'b0, ~VEC[i][5], ~VEC[i][5]});
         wr_req = VEC[i][4]; rd_req = VEC[i][3];
         #1;
         check("R3", {1'b0, wr_en, rd_en, oe}, {1'b0, VEC[i][2:0]});
         wr_req = 0; rd_req = 0;
      end

      // R9: idle output in cascade mode
      do_reset(1'b0, 1'b1);
      tick();
      check("R9", {3'b0, xout}, 4'h1);

      // R4: write hand-off
      last_wr = 1; tick(); last_wr = 0;
      check("R4", {2'b0, wr_tok, xout}, {2'b0, 1'b0, 1'b1});
      tick(); check("R4", {3'b0, xout}, 4'h0);
      tick(); check("R6", {3'b0, xout}, 4'h1);
      wr_req = 1; #1; check("R3", {3'b0, wr_en}, 4'h0); wr_req = 0;

      // R5: read hand-off
      last_rd = 1; tick(); last_rd = 0;
      check("R5", {2'b0, rd_tok, oe}, 4'h0);
      tick(); check("R5", {3'b0, xout}, 4'h0);
      tick(); check("R5", {3'b0, xout}, 4'h1);

      // R6: both hand-offs on one edge
      do_reset(1'b0, 1'b1);
      last_wr = 1; last_rd = 1; tick(); last_wr = 0; last_rd = 0;
      check("R6", {2'b0, wr_tok, rd_tok}, 4'h0);
      tick(); check("R6", {3'b0, xout}, 4'h0);
      tick(); check("R6", {3'b0, xout}, 4'h1);
      tick(); check("R6", {3'b0, xout}, 4'h0);
      tick(); check("R6", {3'b0, xout}, 4'h1);
      tick(); check("R6", {3'b0, xout}, 4'h1);

      // R8: stray events without tokens
      do_reset(1'b1, 1'b1);
      last_wr = 1; last_rd = 1; tick(); last_wr = 0; last_rd = 0;
      for (int k = 0; k < 3; k++) begin
         tick();
         check("R8", {1'b0, wr_tok, rd_tok, xout}, 4'h1);
      end

      // R7: received pulses alternate write then read
      tick(); check("R7", {2'b0, wr_tok, rd_tok}, 4'h0);
      xin = 0; tick(); xin = 1;
      check("R7", {2'b0, wr_tok, rd_tok}, 4'b0010);
      tick(); check("R7", {2'b0, wr_tok, rd_tok}, 4'b0010);
      xin = 0; tick(); xin = 1;
      check("R7", {1'b0, wr_tok, rd_tok, oe}, 4'b0111);

      // R2: single-device mode, both strap settings
      for (int s = 0; s < 2; s++) begin
         do_reset(s[0], 1'b0);
         xin = 0;
         check("R2", {2'b0, wr_tok, rd_tok}, 4'b0011);
         half_full = 1; #1; check("R2", {3'b0, xout}, 4'h0);
         half_full = 0; #1; check("R2", {3'b0, xout}, 4'h1);
         last_wr = 1; last_rd = 1; tick(); last_wr = 0; last_rd = 0;
         tick(); tick();
         check("R2", {1'b0, wr_tok, rd_tok, xout}, 4'b0111);
         xin = 1;
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule